// File: doc/BRIEF.md
# I2C Counted Receive Burst Engine

This block is the receive half of an I2C bus master. Software arms it with one control byte that carries a byte count and a flag choosing how the final byte is answered. The engine then generates SCL pulses, shifts in that many bytes from the addressed slave and answers each one on the ninth clock. Received bytes are queued in a 64-entry receive FIFO that software drains one byte per read strobe. When the count runs out, a read-complete flag rises.

A read longer than the FIFO is split into several bursts. Every burst except the last is armed with the final-byte NAK flag clear. The engine then ends that burst by acknowledging its last byte and keeping SCL pulled low, so the transfer continues without a new START. The closing burst sets the flag, so the slave sees a NAK on the last byte and the bus is left released for the STOP logic. START, STOP, addressing and transmit belong to other units.

Top module: `rxb_burst_rx`

## Requirements
- R1: A write of the control byte while idle arms a burst. Bits [6:0] hold the byte count and bit 7 is the final-byte NAK flag. A count above 64 is treated as 64.
- R2: A burst of N bytes produces exactly 9*N SCL rising edges. Data bits are taken from SDA at each SCL rising edge, most significant bit first.
- R3: On the ninth clock of each byte the engine drives SDA low (ACK). The exception is the final byte of a burst armed with the NAK flag set: there SDA is left released, so a high level is a NAK.
- R4: Each received byte enters a 64-entry FIFO. `rd_data` shows the oldest byte, a `rd_pop` strobe removes it, and `rx_empty` is high exactly when the FIFO holds nothing.
- R5: `rd_done` rises when the last counted byte has been acknowledged. It stays high while the engine is idle and clears when a burst with a nonzero count is armed.
- R6: A control write with count zero produces no SCL activity, leaves the line states unchanged and sets `rd_done` on the next cycle.
- R7: After a burst armed with NAK set, SCL and SDA are both released. After a burst armed with NAK clear, SCL stays driven low and SDA is released.
- R8: A control write while a burst is running is ignored.
- R9: Before starting a byte, the engine holds SCL low while the FIFO is full, so no byte is ever lost.
- R10: The engine changes its SDA drive only while it holds SCL low, and only after SCL has already been low for a cycle.
- R11: During a high phase the engine waits for the SCL line to read high before sampling. A slave that stretches the clock therefore delays the bit without corrupting it.
- R12: A `rd_pop` strobe on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: [6:0] count, [7] final-byte NAK |
| rd_pop | input | 1 | Pop strobe for the receive FIFO |
| rd_data | output | 8 | Oldest byte in the receive FIFO |
| rx_empty | output | 1 | Receive FIFO holds no byte |
| rd_done | output | 1 | Read-complete flag |
| busy | output | 1 | Burst in progress |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drv | output | 1 | 1 pulls SCL low (open drain) |
| sda_in | input | 1 | Sensed SDA line level |
| sda_drv | output | 1 | 1 pulls SDA low (open drain) |

## Verification
A slave model on the bench serves a byte stream computed from a global byte index. Bursts of 1, 2, 3, 5 and 64 bytes with NAK set show whether the count, the bit order and the placement of the NAK are right. A NAK-clear burst followed by a NAK-set burst, and an over-range count, show chaining and count clamping. A zero count, a write during a running burst, and an undrained full FIFO followed by a further burst each test a stall or ignore path. A stretched SCL high phase and pops on an empty FIFO are also applied, and each case is judged by SCL edge counts, logged ACK levels and popped data.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int CTRL_CNT_W  = 7;
    localparam int CTRL_NAK_IX = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_TAIL = 2'd3
    } rxb_state_e;

    typedef struct packed {
        logic                  nak_last;
        logic [CTRL_CNT_W-1:0] count;
    } rxb_ctrl_t;

    function automatic logic [CTRL_CNT_W-1:0] clamp_count(
        input logic [CTRL_CNT_W-1:0] raw,
        input int unsigned           lim
    );
        if (int'(raw) > lim)
            return CTRL_CNT_W'(lim);
        return raw;
    endfunction

endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && !full;
    assign head    = mem[rptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/rxb_cmd_dec.sv
module rxb_cmd_dec
    import rxb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          we,
    input  logic [7:0]    wdata,
    input  logic          busy,
    output logic          start,
    output logic          zero,
    output logic [CW-1:0] cnt,
    output logic          nak
);
    rxb_ctrl_t             word;
    logic [CTRL_CNT_W-1:0] lim_cnt;

    assign word    = rxb_ctrl_t'(wdata);
    assign lim_cnt = clamp_count(word.count, DEPTH);
    assign cnt     = CW'(lim_cnt);
    assign nak     = word.nak_last;
    assign start   = we && !busy && (lim_cnt != '0);
    assign zero    = we && !busy && (lim_cnt == '0);
endmodule

// File: rtl/rxb_seq.sv
module rxb_seq
    import rxb_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int DEPTH    = 64,
    localparam int TW      = $clog2(HALF_CYC) + 1,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          zero,
    input  logic [CW-1:0] cnt,
    input  logic          nak,
    input  logic          fifo_full,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drv,
    output logic          sda_drv,
    output logic          push,
    output logic [7:0]    push_data,
    output logic          busy,
    output logic          done
);
    rxb_state_e    state;
    logic [TW-1:0] tmr;
    logic [3:0]    bit_ix;
    logic [CW-1:0] left;
    logic          nak_q;
    logic [7:0]    shreg;
    logic          ack_now;
    logic          low_end, high_end;

    assign busy      = (state != ST_IDLE);
    assign push_data = shreg;
    assign ack_now   = !(nak_q && left == CW'(1));
    assign low_end   = (tmr == TW'(HALF_CYC - 1));
    assign high_end  = (tmr == TW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            bit_ix  <= '0;
            left    <= '0;
            nak_q   <= 1'b0;
            shreg   <= '0;
            scl_drv <= 1'b0;
            sda_drv <= 1'b0;
            push    <= 1'b0;
            done    <= 1'b0;
        end else begin
            push <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        left    <= cnt;
                        nak_q   <= nak;
                        done    <= 1'b0;
                        bit_ix  <= '0;
                        tmr     <= '0;
                        scl_drv <= 1'b1;
                        state   <= ST_LOW;
                    end else if (zero) begin
                        done <= 1'b1;
                    end
                end
                ST_LOW: begin
                    // a new byte waits here, SCL low, until the FIFO has room
                    if (!(bit_ix == 4'd0 && tmr == '0 && fifo_full)) begin
                        if (tmr == TW'(1))
                            sda_drv <= (bit_ix == 4'd8) && ack_now;
                        if (low_end) begin
                            scl_drv <= 1'b0;
                            tmr     <= '0;
                            state   <= ST_HIGH;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                ST_HIGH: begin
                    if (tmr == '0) begin
                        // wait for the line to be seen high (slave stretch)
                        if (scl_in) begin
                            if (bit_ix != 4'd8)
                                shreg <= {shreg[6:0], sda_in};
                            tmr <= TW'(1);
                        end
                    end else if (high_end) begin
                        tmr <= '0;
                        if (bit_ix == 4'd8) begin
                            left <= left - 1'b1;
                            if (left == CW'(1)) begin
                                if (nak_q) begin
                                    done  <= 1'b1;
                                    state <= ST_IDLE;
                                end else begin
                                    scl_drv <= 1'b1;
                                    state   <= ST_TAIL;
                                end
                            end else begin
                                bit_ix  <= '0;
                                scl_drv <= 1'b1;
                                state   <= ST_LOW;
                            end
                        end else begin
                            if (bit_ix == 4'd7)
                                push <= 1'b1;
                            bit_ix  <= bit_ix + 1'b1;
                            scl_drv <= 1'b1;
                            state   <= ST_LOW;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_TAIL: begin
                    // drop the final ACK only once SCL is already low
                    if (tmr == TW'(1)) begin
                        sda_drv <= 1'b0;
                        done    <= 1'b1;
                        tmr     <= '0;
                        state   <= ST_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxb_burst_rx.sv
module rxb_burst_rx #(
    parameter int FIFO_DEPTH = 64,
    parameter int HALF_CYC   = 4,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rx_empty,
    output logic       rd_done,
    output logic       busy,
    input  logic       scl_in,
    output logic       scl_drv,
    input  logic       sda_in,
    output logic       sda_drv
);
    logic          cmd_start, cmd_zero, cmd_nak;
    logic [CW-1:0] cmd_cnt;
    logic          byte_push, fifo_full;
    logic [7:0]    byte_val;

    rxb_cmd_dec #(.DEPTH(FIFO_DEPTH)) u_dec (
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .busy  (busy),
        .start (cmd_start),
        .zero  (cmd_zero),
        .cnt   (cmd_cnt),
        .nak   (cmd_nak)
    );

    rxb_seq #(.HALF_CYC(HALF_CYC), .DEPTH(FIFO_DEPTH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_start),
        .zero      (cmd_zero),
        .cnt       (cmd_cnt),
        .nak       (cmd_nak),
        .fifo_full (fifo_full),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_drv   (scl_drv),
        .sda_drv   (sda_drv),
        .push      (byte_push),
        .push_data (byte_val),
        .busy      (busy),
        .done      (rd_done)
    );

    rxb_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (byte_push),
        .push_data (byte_val),
        .pop       (rd_pop),
        .head      (rd_data),
        .empty     (rx_empty),
        .full      (fifo_full)
    );
endmodule

// File: rtl/rxb_burst_chk.sv
module rxb_burst_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_drv,
    input logic       sda_drv,
    input logic       busy,
    input logic       rd_done,
    input logic       rd_pop,
    input logic       rx_empty,
    input logic       byte_push,
    input logic       fifo_full,
    input logic       ctrl_we,
    input logic [6:0] ctrl_cnt
);
    // R10: SDA drive moves only inside an SCL-low window already one cycle old
    p_sda_edge_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_drv) |-> (scl_drv && $past(scl_drv)));

    // R9: a byte is never pushed into a full FIFO
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        byte_push |-> !fifo_full);

    // R6: zero count completes at once with no SCL movement
    p_zero_done_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !busy && ctrl_cnt == 7'd0) |=> (rd_done && !busy && $stable(scl_drv)));

    // R5: read-complete is only seen while idle
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !busy);

    // R12: popping an empty FIFO leaves it empty
    p_pop_empty_r12: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && rd_pop && !byte_push) |=> rx_empty);
endmodule

bind rxb_burst_rx rxb_burst_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_drv   (scl_drv),
    .sda_drv   (sda_drv),
    .busy      (busy),
    .rd_done   (rd_done),
    .rd_pop    (rd_pop),
    .rx_empty  (rx_empty),
    .byte_push (byte_push),
    .fifo_full (fifo_full),
    .ctrl_we   (ctrl_we),
    .ctrl_cnt  (ctrl_wdata[6:0])
);

// File: tb/sim_rxb_burst_rx.sv
`timescale 1ns/1ps
module sim_rxb_burst_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       rd_pop = 1'b0;
    logic       stretch = 1'b0;
    logic [7:0] rd_data;
    logic       rx_empty, rd_done, busy, scl_drv, sda_drv;
    logic       scl_line, sda_line, slave_low;
    logic [7:0] cur_pat;

    int checks = 0, fails = 0, nxt = 0;
    int bit_pos, byte_idx, rises, viol;
    logic seen_rise, prev_scl, prev_sda_drv, prev_scl_drv;
    logic ack_log [0:511];

    rxb_burst_rx u0 (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .rd_pop(rd_pop), .rd_data(rd_data), .rx_empty(rx_empty),
        .rd_done(rd_done), .busy(busy), .scl_in(scl_line), .scl_drv(scl_drv),
        .sda_in(sda_line), .sda_drv(sda_drv)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    assign cur_pat   = pat(byte_idx);
    assign slave_low = (bit_pos < 8) && !cur_pat[3'(7 - bit_pos)];
    assign scl_line  = ~(scl_drv | stretch);
    assign sda_line  = ~(sda_drv | slave_low);

    // slave model and bus monitor
    always @(posedge clk) begin
        if (rst) begin
            prev_scl <= 1'b1; bit_pos <= 0; byte_idx <= 0; rises <= 0;
            seen_rise <= 1'b0; viol <= 0; prev_sda_drv <= 1'b0; prev_scl_drv <= 1'b0;
        end else begin
            prev_scl     <= scl_line;
            prev_sda_drv <= sda_drv;
            prev_scl_drv <= scl_drv;
            if (sda_drv !== prev_sda_drv && !(scl_drv && prev_scl_drv))
                viol <= viol + 1;
            if (!prev_scl && scl_line) begin
                rises     <= rises + 1;
                seen_rise <= 1'b1;
                if (bit_pos == 8) ack_log[byte_idx] <= sda_line;
            end else if (prev_scl && !scl_line && seen_rise) begin
                seen_rise <= 1'b0;
                if (bit_pos == 8) begin
                    bit_pos  <= 0;
                    byte_idx <= byte_idx + 1;
                end else begin
                    bit_pos <= bit_pos + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic arm(input logic [7:0] w);
        @(negedge clk);
        ctrl_wdata = w;
        ctrl_we    = 1'b1;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic wait_done;
        while (!rd_done) @(negedge clk);
    endtask

    task automatic pop_check(input int b, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            chk(!rx_empty && rd_data == pat(b + k), req, "popped byte",
                int'(rd_data), int'(pat(b + k)));
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
        end
    endtask

    task automatic finish_burst(input int n, input bit nak, input int b,
                                input int r0, input bit do_pop);
        int bad;
        bad = 0;
        wait_done;
        chk(rises - r0 == 9 * n, "R2", "scl rising edges", rises - r0, 9 * n);
        for (int k = 0; k < n; k++)
            if (ack_log[b + k] !== ((nak && k == n - 1) ? 1'b1 : 1'b0)) bad++;
        chk(bad == 0, "R3", "ack/nak level mismatches", bad, 0);
        if (nak)
            chk(!scl_drv && !sda_drv, "R7", "lines after nak burst",
                int'({scl_drv, sda_drv}), 0);
        else
            chk(scl_drv && !sda_drv, "R7", "lines after ack burst",
                int'({scl_drv, sda_drv}), 2);
        chk(rd_done && !busy, "R5", "done and idle", int'({rd_done, busy}), 2);
        nxt = b + n;
        if (do_pop) begin
            pop_check(b, n, "R4");
            chk(rx_empty, "R4", "empty after drain", int'(rx_empty), 1);
        end
    endtask

    task automatic run_burst(input int raw, input bit nak);
        int n, b, r0;
        n  = (raw > 64) ? 64 : raw;
        b  = nxt;
        r0 = rises;
        arm({nak, 7'(raw)});
        finish_burst(n, nak, b, r0, 1'b1);
    endtask

    initial begin
        int r, b, b2, r1;
        logic sd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_empty, "R4", "reset empty", int'(rx_empty), 1);
        chk(!rd_done && !busy, "R5", "reset done/busy", int'({rd_done, busy}), 0);
        chk(!scl_drv && !sda_drv, "R7", "reset lines", int'({scl_drv, sda_drv}), 0);

        // R2 R3 R4: single bursts of several lengths with final NAK
        run_burst(1, 1'b1);
        run_burst(2, 1'b1);
        run_burst(3, 1'b1);
        run_burst(5, 1'b1);
        run_burst(64, 1'b1);

        // R7: chained bursts, first leaves SCL held
        run_burst(4, 1'b0);
        run_burst(3, 1'b1);

        // R1: count above 64 clamps
        r = rises;
        run_burst(100, 1'b1);
        chk(rises - r == 576, "R1", "clamped burst edges", rises - r, 576);

        // R6: zero count
        r  = rises;
        sd = scl_drv;
        arm(8'h80);
        chk(rd_done && !busy, "R6", "zero count done", int'({rd_done, busy}), 2);
        repeat (40) @(negedge clk);
        chk(rises == r && scl_drv == sd, "R6", "no scl activity", rises - r, 0);

        // R8: write during a running burst is ignored
        b = nxt; r = rises;
        arm(8'h85);
        repeat (30) @(negedge clk);
        arm(8'h82);
        finish_burst(5, 1'b1, b, r, 1'b1);
        chk(rises - r == 45, "R8", "edges with ignored write", rises - r, 45);

        // R9: full FIFO stalls the next burst
        b = nxt; r = rises;
        arm(8'h40);
        finish_burst(64, 1'b0, b, r, 1'b0);
        b2 = nxt; r1 = rises;
        arm(8'h83);
        repeat (300) @(negedge clk);
        chk(busy && rises == r1 && scl_drv, "R9", "stall edges while full", rises - r1, 0);
        pop_check(b, 64, "R9");
        finish_burst(3, 1'b1, b2, r1, 1'b1);

        // R11: slave stretches the clock
        b = nxt; r = rises;
        arm(8'h84);
        repeat (20) @(negedge clk);
        while (!scl_drv) @(negedge clk);
        stretch = 1'b1;
        r1 = rises;
        repeat (40) @(negedge clk);
        chk(rises == r1 && busy, "R11", "no edge while stretched", rises - r1, 0);
        stretch = 1'b0;
        finish_burst(4, 1'b1, b, r, 1'b1);

        // R12: pop on empty FIFO
        chk(rx_empty, "R12", "empty before pops", int'(rx_empty), 1);
        rd_pop = 1'b1;
        repeat (3) @(negedge clk);
        rd_pop = 1'b0;
        chk(rx_empty, "R12", "still empty after pops", int'(rx_empty), 1);
        run_burst(2, 1'b1);

        chk(viol == 0, "R10", "sda changes outside scl low", viol, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule